// File: doc/BRIEF.md
# Push-Button Power-On Lockout Sequencer

This block is a clocked state machine that brings system power up from a push-button press. It keeps power up only when a host processor confirms the start. A press is first qualified over a debounce interval, with the button held and the supply-good flag true throughout. Power enable is then raised and a reset pulse is issued to the host. While this happens the host's hold-confirm pin is ignored, and a pull-down control keeps that pin low if the host leaves it floating.

The host confirmation is sampled once, at the first of two events: release of the button, or the end of a blanking window that opens when enable rises. If the hold level is high at that moment, the block moves to normal operation and emits a one-cycle strobe that tells neighbouring monitors they may begin. If the hold level is low, power is dropped. In normal operation the host ends the session by pulling hold low. All timing is counted in clock cycles and set by parameters. The polarity of the enable pin is chosen by a parameter.

Top module: `pwr_lockout_seq`

## Requirements
- R1: After reset the block is in standby: standby flag high, enable inactive, reset output high, pull-down control low, strobe low.
- R2: In standby, a high-to-low transition of `btn_ni` starts qualification. Enable becomes active exactly `DEB_CYC` clock edges after the edge that sees the transition, provided the button stays low and `supply_ok_i` stays high at each of those edges.
- R3: Releasing the button (`btn_ni` high) during qualification returns the block to standby on that edge, without raising enable.
- R4: `supply_ok_i` low at any qualification edge clears the count. Enable then needs `DEB_CYC` further consecutive good edges with the button held.
- R5: `rst_no` is low for exactly `REC_CYC` cycles starting with the cycle in which enable becomes active (shorter only if startup ends earlier), and high otherwise.
- R6: `hold_pd_o` is high during qualification and startup and low otherwise. During startup a change on `hold_i` has no effect on enable until release or window expiry.
- R7: A button release during startup samples `hold_i`. If high, the block enters normal operation with enable kept. If low, enable is inactive from the next cycle and the block is back in standby.
- R8: If the button is still held when `BLANK_CYC` cycles of startup have elapsed, `hold_i` is sampled then with the same outcome as R7. A later release does not change the outcome.
- R9: In normal operation, `hold_i` low at a clock edge deactivates enable and returns the block to standby.
- R10: In standby only a high-to-low button transition starts qualification. A button held low through reset, or still held after a failed startup, starts nothing until it is released and pressed again.
- R11: With `EN_ACTIVE_HIGH`=1, `pwr_en_o` is high when power is on. With 0, it is low when power is on.
- R12: `start_done_o` is high for exactly one cycle, the first cycle of normal operation, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_ni | input | 1 | Synchronized push-button, low when pressed |
| supply_ok_i | input | 1 | Supply above start threshold |
| hold_i | input | 1 | Host hold-confirm level |
| pwr_en_o | output | 1 | Power enable, polarity per `EN_ACTIVE_HIGH` |
| rst_no | output | 1 | Host reset, active low |
| hold_pd_o | output | 1 | Enables pull-down on the hold pin |
| standby_o | output | 1 | Block is idle in standby |
| start_done_o | output | 1 | One-cycle strobe on entry to normal operation |

## Verification
The bench builds the main instance with a debounce of 8 cycles, a recovery of 4 and a blanking window of 20. It also builds a second instance with inverted enable polarity and drives it from the same inputs. These short periods bring both exits from startup within reach of a few dozen cycles of stimulus: release before expiry, and expiry with the button held. They also let a supply dropout land in the middle of a debounce count. Thousands of random cycles then wander through every state many times.

// File: rtl/pls_pkg.sv
`timescale 1ns/1ps
package pls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEB  = 2'd1,
    ST_BOOT = 2'd2,
    ST_RUN  = 2'd3
  } pls_state_e;
endpackage

// File: rtl/pls_fall_det.sv
`timescale 1ns/1ps
module pls_fall_det #(
  parameter bit PREV_RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic fall_o
);
  logic prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= PREV_RST;
    else         prev_q <= in_i;
  end
  assign fall_o = prev_q & ~in_i;
endmodule

// File: rtl/pls_timer.sv
`timescale 1ns/1ps
module pls_timer #(
  parameter int unsigned MATCH = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  localparam int unsigned W = $clog2(MATCH + 2);
  localparam logic [W-1:0] MATCH_V = W'(MATCH);

  logic [W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (inc_i && cnt_q != MATCH_V) cnt_q <= cnt_q + 1'b1;
  end
  assign hit_o = (cnt_q == MATCH_V);
endmodule

// File: rtl/pls_en_drive.sv
`timescale 1ns/1ps
module pls_en_drive #(
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic on_i,
  output logic pin_o
);
  generate
    if (ACTIVE_HIGH) begin : g_hi
      assign pin_o = on_i;
    end else begin : g_lo
      assign pin_o = ~on_i;
    end
  endgenerate
endmodule

// File: rtl/pwr_lockout_seq.sv
`timescale 1ns/1ps
module pwr_lockout_seq
  import pls_pkg::*;
#(
  parameter int unsigned DEB_CYC        = 8,
  parameter int unsigned REC_CYC        = 4,
  parameter int unsigned BLANK_CYC      = 20,
  parameter bit          EN_ACTIVE_HIGH = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  input  logic supply_ok_i,
  input  logic hold_i,
  output logic pwr_en_o,
  output logic rst_no,
  output logic hold_pd_o,
  output logic standby_o,
  output logic start_done_o
);
  localparam int unsigned DEB_LAST   = DEB_CYC - 1;
  localparam int unsigned BLANK_LAST = BLANK_CYC - 1;

  pls_state_e state_q, state_d;
  logic       done_q, done_d;
  logic       btn_fall, deb_hit, blank_hit, rec_hit;
  logic       in_deb, in_boot, pwr_on;

  assign in_deb  = (state_q == ST_DEB);
  assign in_boot = (state_q == ST_BOOT);

  // previous level resets as "pressed" so a button held through reset is no edge
  pls_fall_det #(.PREV_RST(1'b0)) u_fall (
    .clk_i (clk_i), .rst_ni(rst_ni), .in_i(btn_ni), .fall_o(btn_fall)
  );

  pls_timer #(.MATCH(DEB_LAST)) u_deb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(~in_deb | ~supply_ok_i), .inc_i(in_deb), .hit_o(deb_hit)
  );

  pls_timer #(.MATCH(BLANK_LAST)) u_blank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(~in_boot), .inc_i(in_boot), .hit_o(blank_hit)
  );

  pls_timer #(.MATCH(REC_CYC)) u_rec (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(~in_boot), .inc_i(in_boot), .hit_o(rec_hit)
  );

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (btn_fall) state_d = ST_DEB;
      ST_DEB: begin
        if (btn_ni)                      state_d = ST_IDLE;
        else if (supply_ok_i && deb_hit) state_d = ST_BOOT;
      end
      ST_BOOT: begin
        // release or window end: one-shot sample of hold
        if (btn_ni || blank_hit) begin
          if (hold_i) begin
            state_d = ST_RUN;
            done_d  = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_RUN: if (!hold_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign pwr_on       = in_boot | (state_q == ST_RUN);
  assign rst_no       = ~(in_boot & ~rec_hit);
  assign hold_pd_o    = in_deb | in_boot;
  assign standby_o    = (state_q == ST_IDLE);
  assign start_done_o = done_q;

  pls_en_drive #(.ACTIVE_HIGH(EN_ACTIVE_HIGH)) u_en (
    .on_i(pwr_on), .pin_o(pwr_en_o)
  );
endmodule

// File: rtl/pls_lockout_chk.sv
`timescale 1ns/1ps
module pls_lockout_chk #(
  parameter bit EN_ACTIVE_HIGH = 1'b1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic hold_i,
  input logic pwr_en_o,
  input logic rst_no,
  input logic hold_pd_o,
  input logic standby_o,
  input logic start_done_o
);
  logic en_on;
  assign en_on = EN_ACTIVE_HIGH ? pwr_en_o : ~pwr_en_o;

  AST_STANDBY_NO_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> !en_on && rst_no && !hold_pd_o && !start_done_o); // R1

  AST_EN_RISE_FROM_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_on) |-> $past(hold_pd_o) && !rst_no); // R2

  AST_RST_ONLY_WITH_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_no |-> en_on && hold_pd_o); // R5

  AST_PD_NOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_pd_o |-> !standby_o); // R6

  AST_RUN_HOLD_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_on && !hold_pd_o && !hold_i |=> !en_on && standby_o); // R9

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_done_o |=> !start_done_o); // R12

  AST_STROBE_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_done_o |-> en_on && !hold_pd_o && $past(hold_pd_o)); // R12
endmodule

bind pwr_lockout_seq pls_lockout_chk #(.EN_ACTIVE_HIGH(EN_ACTIVE_HIGH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i), .pwr_en_o(pwr_en_o),
  .rst_no(rst_no), .hold_pd_o(hold_pd_o), .standby_o(standby_o),
  .start_done_o(start_done_o)
);

// File: tb/pwr_lockout_seq_test.sv
`timescale 1ns/1ps
module pwr_lockout_seq_test;
  localparam int DEB = 8, REC = 4, BLANK = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic btn = 1'b1, ok = 1'b1, hold = 1'b0;
  logic en, rst_o, pd, stby, done, en_lo, rst_o2, pd2, stby2, done2;
  int   errors = 0, checks = 0;
  bit   finished = 0;

  always #2.5 clk = ~clk;

  pwr_lockout_seq #(.DEB_CYC(DEB), .REC_CYC(REC), .BLANK_CYC(BLANK), .EN_ACTIVE_HIGH(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .btn_ni(btn), .supply_ok_i(ok), .hold_i(hold),
    .pwr_en_o(en), .rst_no(rst_o), .hold_pd_o(pd), .standby_o(stby), .start_done_o(done));

  pwr_lockout_seq #(.DEB_CYC(DEB), .REC_CYC(REC), .BLANK_CYC(BLANK), .EN_ACTIVE_HIGH(1'b0)) uut_lo (
    .clk_i(clk), .rst_ni(rst_n), .btn_ni(btn), .supply_ok_i(ok), .hold_i(hold),
    .pwr_en_o(en_lo), .rst_no(rst_o2), .hold_pd_o(pd2), .standby_o(stby2), .start_done_o(done2));

  // reference model: 0 idle, 1 qualify, 2 startup, 3 run
  int m_st, m_dc, m_t;
  bit m_prev, m_strobe;

  task automatic model_reset();
    m_st = 0; m_dc = 0; m_t = 0; m_prev = 1'b0; m_strobe = 1'b0;
  endtask

  task automatic model_step();
    m_strobe = 1'b0;
    case (m_st)
      0: if (m_prev && !btn) begin m_st = 1; m_dc = 0; end
      1: begin
        if (btn) m_st = 0;
        else if (!ok) m_dc = 0;
        else if (m_dc == DEB - 1) begin m_st = 2; m_t = 0; end
        else m_dc++;
      end
      2: begin
        if (btn || m_t == BLANK - 1) begin
          if (hold) begin m_st = 3; m_strobe = 1'b1; end
          else m_st = 0;
        end else m_t++;
      end
      default: if (!hold) m_st = 0;
    endcase
    m_prev = btn;
  endtask

  function automatic bit exp_en();    return m_st >= 2; endfunction
  function automatic bit exp_rst();   return !(m_st == 2 && m_t < REC); endfunction
  function automatic bit exp_pd();    return m_st == 1 || m_st == 2; endfunction
  function automatic bit exp_stby();  return m_st == 0; endfunction

  task automatic chk(input bit c, input string req, input int act, input int exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(en == exp_en(), "R2 enable vs model", en, exp_en());
    chk(rst_o == exp_rst(), "R5 reset vs model", rst_o, exp_rst());
    chk(pd == exp_pd(), "R6 pulldown vs model", pd, exp_pd());
    chk(stby == exp_stby(), "R1 standby vs model", stby, exp_stby());
    chk(done == m_strobe, "R12 strobe vs model", done, m_strobe);
    chk(en_lo == !exp_en(), "R11 inverted enable", en_lo, !exp_en());
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    #1;
    compare();
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; model_reset();
    #12;
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    void'($urandom(32'd4711));
    do_reset();
    // R1 reset state
    chk(stby == 1 && en == 0 && rst_o == 1 && pd == 0 && done == 0, "R1 reset state", stby, 1);
    chk(en_lo == 1, "R11 inactive low-polarity pin high", en_lo, 1);
    repeat (3) step();

    // R2/R5/R6/R7/R12/R9 successful start by release
    btn = 0; step();
    chk(pd == 1, "R6 pulldown in qualify", pd, 1);
    repeat (DEB - 1) step();
    chk(en == 0, "R2 not yet enabled", en, 0);
    step();
    chk(en == 1, "R2 enable after debounce", en, 1);
    chk(rst_o == 0, "R5 reset low at enable", rst_o, 0);
    chk(en_lo == 0, "R11 active low-polarity pin low", en_lo, 0);
    repeat (REC - 1) step();
    chk(rst_o == 0, "R5 reset still low", rst_o, 0);
    step();
    chk(rst_o == 1, "R5 reset released", rst_o, 1);
    hold = 1; step();
    chk(en == 1 && pd == 1 && done == 0, "R6 hold ignored in startup", done, 0);
    btn = 1; step();
    chk(done == 1 && en == 1 && stby == 0, "R7 release with hold high", done, 1);
    step();
    chk(done == 0 && pd == 0, "R12 strobe single cycle", done, 0);
    hold = 0; step();
    chk(en == 0 && stby == 1, "R9 hold low powers down", en, 0);

    // R7 release with hold low
    btn = 0; repeat (DEB + 1) step();
    chk(en == 1, "R2 enable again", en, 1);
    btn = 1; step();
    chk(en == 0 && stby == 1, "R7 release with hold low", en, 0);

    // R8 expiry with hold low, later release no effect
    btn = 0; repeat (DEB + 1) step();
    repeat (BLANK - 1) step();
    chk(en == 1, "R8 enabled before expiry", en, 1);
    step();
    chk(en == 0, "R8 expiry hold low drops", en, 0);
    repeat (3) step();
    btn = 1; step(); repeat (5) step();
    chk(en == 0 && stby == 1, "R10 release after failed start", en, 0);

    // R8 expiry with hold high
    btn = 0; repeat (DEB + 1) step();
    hold = 1; repeat (BLANK) step();
    chk(done == 1 && en == 1, "R8 expiry hold high runs", done, 1);
    btn = 1; step();
    chk(en == 1, "R8 release after run keeps power", en, 1);
    hold = 0; step();
    chk(en == 0, "R9 power down", en, 0);

    // R4 supply dropout during debounce
    btn = 0; step();
    repeat (DEB - 3) step();
    ok = 0; step(); ok = 1;
    repeat (DEB - 1) step();
    chk(en == 0, "R4 count restarted", en, 0);
    step();
    chk(en == 1, "R4 enable after full recount", en, 1);
    btn = 1; step();

    // R3 release during debounce
    btn = 0; repeat (4) step();
    btn = 1; step();
    chk(stby == 1 && pd == 0, "R3 release aborts qualify", stby, 1);
    repeat (DEB + 4) step();
    chk(en == 0, "R3 no enable", en, 0);

    // R10 button held through reset
    btn = 0;
    do_reset();
    repeat (DEB + 10) step();
    chk(stby == 1 && en == 0, "R10 held button no edge", stby, 1);
    btn = 1; step();

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(11) == 0) btn = ~btn;
      if (ok && $urandom_range(39) == 0) ok = 0;
      else if (!ok && $urandom_range(2) == 0) ok = 1;
      if ($urandom_range(14) == 0) hold = ~hold;
      step();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule